// File: doc/BRIEF.md
# Keyed-Lock GPIO Bank Controller

This block is one bank of general-purpose pins, up to 32 wide, behind a simple 32-bit register port. Each pin holds three state bits: an output-data bit and two mode bits. The mode bits select one of four pad behaviours: released input, push-pull, sink-only (pull low or float), and source-only (drive high or float). From the pin's state the block derives an output value and an output enable for each pad. Each pad's input level passes through a two-flop synchronizer and can be read back.

Software moves the output data with set and clear strobes, which are always accepted. The mode bits take writes through direct registers and through bitwise set and clear aliases. Every mode write is ignored unless a key register has first been armed by writing a fixed 16-bit key. Writing zero disarms it again. A bank may implement fewer than 32 pins. The upper bits are then absent: they read as zero and drop writes.

Top module: `gpio_lockbank`

## Requirements
- R1: After reset all mode bits and output-data bits are 0, every pad has output enable 0, and the key register reads 0.
- R2: A write to offset 0x14 sets the output-data bit of each pin whose write-data bit is 1. A write to offset 0x18 clears the output-data bit of each such pin. Pins written 0 keep their value. These writes are accepted whether or not the key is armed.
- R3: While the key is armed, three kinds of write change the mode bits. Direct writes replace mode1 (offset 0x08) or mode0 (offset 0x0C), and both read back at those offsets. A 1 written to offset 0x54 sets mode0 for that pin. A 1 written to 0x58 clears mode0, and a 1 written to 0x50 clears mode1. Pins written 0 are unchanged.
- R4: The pair {mode1,mode0} sets how each pad drives. With 00 the pad is released. With 01 the pad drives the output-data bit. With 10 it drives 0 when data is 0 and is released when data is 1. With 11 it is released when data is 0 and drives 1 when data is 1. A released pad has output enable 0 and output value 0.
- R5: The key register is at offset 0x00. Writing 0xD42F to bits 15:0 arms it. Writing 0 there disarms it. Any other value leaves the state unchanged. A read returns the armed state in bit 31 and 0 in every other bit.
- R6: While the key is disarmed, every mode write, whether direct or through an alias, leaves both mode registers unchanged.
- R7: A read of offset 0x04 returns the pad inputs after a two-flop synchronizer. A new pad level appears in a read whose request is sampled on the third rising edge after the level is applied, and not earlier.
- R8: Bits above the implemented pin count read as 0 and ignore writes. Reads of the write-only offsets (0x14, 0x18, 0x50, 0x54, 0x58) and of unmapped offsets return 0.
- R9: Read data is registered. It is valid after the edge that samples the read request, and it holds until the next read request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the bank |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pad_out | output | NPINS | Per-pin drive value |
| pad_oe | output | NPINS | Per-pin output enable |

## Verification
Register writes take effect on the edge that samples them. Because the pad drive logic is combinational from the registers, pad_oe and pad_out are due right after that same edge. The bench therefore drives each request at a falling edge and samples at the next falling edge. A read returns its data one edge after the request, so the read task samples rd_data at the falling edge after the sampling edge. A key write lets a mode write in the very next cycle take effect. The synchronizer test issues three back-to-back reads after changing pad_in and expects the old value twice, then the new one.

// File: rtl/gpio_lockbank_pkg.sv
package gpio_lockbank_pkg;

  localparam int unsigned REG_W = 32;

  // Register offsets (byte addresses within the bank)
  localparam logic [7:0] OFS_KEY    = 8'h00;
  localparam logic [7:0] OFS_DIN    = 8'h04;
  localparam logic [7:0] OFS_M1     = 8'h08;
  localparam logic [7:0] OFS_M0     = 8'h0C;
  localparam logic [7:0] OFS_DSET   = 8'h14;
  localparam logic [7:0] OFS_DCLR   = 8'h18;
  localparam logic [7:0] OFS_M1CLR  = 8'h50;
  localparam logic [7:0] OFS_M0SET  = 8'h54;
  localparam logic [7:0] OFS_M0CLR  = 8'h58;

  localparam logic [15:0] KEY_ARM    = 16'hD42F;
  localparam logic [15:0] KEY_DISARM = 16'h0000;

  typedef enum logic [1:0] {
    PM_INPUT    = 2'b00,
    PM_PUSHPULL = 2'b01,
    PM_SINK     = 2'b10,
    PM_SOURCE   = 2'b11
  } pad_mode_e;

  typedef struct packed {
    logic oe;
    logic val;
  } pad_drv_t;

  // Per-pin drive decision from mode bits and output data.
  function automatic pad_drv_t drive_of(input logic m1, input logic m0, input logic dout);
    pad_drv_t  d;
    pad_mode_e m;
    m = pad_mode_e'({m1, m0});
    d = '0;
    unique case (m)
      PM_INPUT:    d = '0;
      PM_PUSHPULL: begin d.oe = 1'b1; d.val = dout; end
      PM_SINK:     begin d.oe = ~dout; d.val = 1'b0; end
      PM_SOURCE:   begin d.oe = dout;  d.val = dout; end
      default:     d = '0;
    endcase
    return d;
  endfunction

  // Apply set/clear masks to a bit vector (set wins nothing: callers keep them exclusive).
  function automatic logic [REG_W-1:0] apply_sc(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] set_m,
                                                input logic [REG_W-1:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

endpackage

// File: rtl/gpio_key_lock.sv
module gpio_key_lock
  import gpio_lockbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [15:0] key_val,
  output logic        lock_active
);

  logic arm_hit;
  logic disarm_hit;
  logic lock_q;

  assign arm_hit    = key_we && (key_val == KEY_ARM);
  assign disarm_hit = key_we && (key_val == KEY_DISARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lock_q <= 1'b0;
    else if (arm_hit)    lock_q <= 1'b1;
    else if (disarm_hit) lock_q <= 1'b0;
  end

  assign lock_active = lock_q;

  a_r5_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    arm_hit |=> lock_active);
  a_r5_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_hit |=> !lock_active);
  a_r5_other_key_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_hit && !disarm_hit) |=> $stable(lock_active));

endmodule

// File: rtl/gpio_mode_regs.sv
module gpio_mode_regs
  import gpio_lockbank_pkg::*;
#(
  parameter int unsigned NPINS = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_active,
  input  logic [NPINS-1:0] wbits,
  input  logic             m1_wr,
  input  logic             m0_wr,
  input  logic             m1_clr,
  input  logic             m0_set,
  input  logic             m0_clr,
  input  logic             d_set,
  input  logic             d_clr,
  output logic [NPINS-1:0] mode1,
  output logic [NPINS-1:0] mode0,
  output logic [NPINS-1:0] dout
);

  logic [NPINS-1:0] mode1_q, mode0_q, dout_q;
  logic [NPINS-1:0] mode1_d, mode0_d, dout_d;
  logic             mode_we_ok;
  logic [REG_W-1:0] zero_w;
  logic [REG_W-1:0] w_ext;

  assign mode_we_ok = lock_active;
  assign zero_w     = '0;
  assign w_ext      = REG_W'(wbits);

  always_comb begin
    mode1_d = mode1_q;
    mode0_d = mode0_q;
    dout_d  = NPINS'(apply_sc(REG_W'(dout_q), d_set ? w_ext : zero_w, d_clr ? w_ext : zero_w));
    if (mode_we_ok) begin
      if (m1_wr) mode1_d = wbits;
      if (m1_clr) mode1_d = NPINS'(apply_sc(REG_W'(mode1_q), zero_w, w_ext));
      if (m0_wr) mode0_d = wbits;
      if (m0_set || m0_clr)
        mode0_d = NPINS'(apply_sc(REG_W'(mode0_q), m0_set ? w_ext : zero_w,
                                  m0_clr ? w_ext : zero_w));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode1_q <= '0;
      mode0_q <= '0;
      dout_q  <= '0;
    end else begin
      mode1_q <= mode1_d;
      mode0_q <= mode0_d;
      dout_q  <= dout_d;
    end
  end

  assign mode1 = mode1_q;
  assign mode0 = mode0_q;
  assign dout  = dout_q;

  a_r6_modes_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_active |=> ($stable(mode1) && $stable(mode0)));
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    d_set |=> ((dout & $past(wbits)) == $past(wbits)));
  a_r2_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    d_clr |=> ((dout & $past(wbits)) == '0));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_lockbank_pkg::*;
#(
  parameter int unsigned NPINS = 32
)(
  input  logic [NPINS-1:0] mode1,
  input  logic [NPINS-1:0] mode0,
  input  logic [NPINS-1:0] dout,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pad_drv_t drv;
    assign drv        = drive_of(mode1[i], mode0[i], dout[i]);
    assign pad_oe[i]  = drv.oe;
    assign pad_out[i] = drv.val;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] din_sync
);

  logic [NPINS-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  assign din_sync = sync_q;

endmodule

// File: rtl/gpio_lockbank.sv
module gpio_lockbank
  import gpio_lockbank_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);

  localparam int unsigned OFS_W = 8;

  logic             wr_ev, rd_ev;
  logic [OFS_W-1:0] ofs;
  logic             key_we, m1_wr, m0_wr, m1_clr, m0_set, m0_clr, d_set, d_clr;
  logic             lock_active;
  logic [NPINS-1:0] mode1, mode0, dout, din_sync;
  logic [31:0]      rd_next, rd_q;

  assign wr_ev = req_valid && req_write;
  assign rd_ev = req_valid && !req_write;
  assign ofs   = OFS_W'(req_addr);

  assign key_we = wr_ev && (ofs == OFS_KEY);
  assign m1_wr  = wr_ev && (ofs == OFS_M1);
  assign m0_wr  = wr_ev && (ofs == OFS_M0);
  assign m1_clr = wr_ev && (ofs == OFS_M1CLR);
  assign m0_set = wr_ev && (ofs == OFS_M0SET);
  assign m0_clr = wr_ev && (ofs == OFS_M0CLR);
  assign d_set  = wr_ev && (ofs == OFS_DSET);
  assign d_clr  = wr_ev && (ofs == OFS_DCLR);

  gpio_key_lock u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_we      (key_we),
    .key_val     (req_wdata[15:0]),
    .lock_active (lock_active)
  );

  gpio_mode_regs #(.NPINS(NPINS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_active (lock_active),
    .wbits       (req_wdata[NPINS-1:0]),
    .m1_wr       (m1_wr),
    .m0_wr       (m0_wr),
    .m1_clr      (m1_clr),
    .m0_set      (m0_set),
    .m0_clr      (m0_clr),
    .d_set       (d_set),
    .d_clr       (d_clr),
    .mode1       (mode1),
    .mode0       (mode0),
    .dout        (dout)
  );

  gpio_pad_drive #(.NPINS(NPINS)) u_drive (
    .mode1   (mode1),
    .mode0   (mode0),
    .dout    (dout),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .din_sync (din_sync)
  );

  always_comb begin
    rd_next = '0;
    unique case (ofs)
      OFS_KEY: rd_next = {lock_active, 31'b0};
      OFS_DIN: rd_next = 32'(din_sync);
      OFS_M1:  rd_next = 32'(mode1);
      OFS_M0:  rd_next = 32'(mode0);
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_ev) rd_q <= rd_next;
  end

  assign rd_data = rd_q;

  a_r4_input_released: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mode1 & ~mode0 & pad_oe) == '0));
  a_r4_sink_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode1 & ~mode0 & pad_oe & pad_out) == '0));
  a_r4_source_never_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode1 & mode0 & pad_oe & ~pad_out) == '0));
  a_r9_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> $stable(rd_data));

endmodule

// File: tb/gpio_lockbank_bench.sv
module gpio_lockbank_bench;

  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   rd_data;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit reported = 0;

  // bench-side model of pin state
  logic [NP-1:0] em1 = '0, em0 = '0, ed = '0;

  always #5 clk = ~clk;

  gpio_lockbank #(.NPINS(NP), .ADDR_W(8)) u_gpio_lockbank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    d = rd_data;
  endtask

  // expected pad behaviour, written as a truth table on mode and data
  task automatic check_pads(input string req);
    logic [NP-1:0] eo, ev;
    for (int i = 0; i < NP; i++) begin
      case ({em1[i], em0[i], ed[i]})
        3'b010: begin eo[i] = 1; ev[i] = 0; end
        3'b011: begin eo[i] = 1; ev[i] = 1; end
        3'b100: begin eo[i] = 1; ev[i] = 0; end
        3'b111: begin eo[i] = 1; ev[i] = 1; end
        default: begin eo[i] = 0; ev[i] = 0; end
      endcase
    end
    check({req, " oe"}, 32'(pad_oe), 32'(eo));
    check({req, " out"}, 32'(pad_out), 32'(ev));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 pad_oe", 32'(pad_oe), 0);
    rd(8'h08, v); check("R1 mode1", v, 0);
    rd(8'h0C, v); check("R1 mode0", v, 0);
    rd(8'h00, v); check("R1 key", v, 0);
  endtask

  task automatic t_key();
    logic [31:0] v;
    wr(8'h00, 32'h0000_1234); rd(8'h00, v); check("R5 wrong key", v, 0);
    wr(8'h00, 32'h0000_D42F); rd(8'h00, v); check("R5 armed", v, 32'h8000_0000);
    wr(8'h00, 32'h0000_5555); rd(8'h00, v); check("R5 other keeps", v, 32'h8000_0000);
    wr(8'h00, 32'h0000_0000); rd(8'h00, v); check("R5 disarmed", v, 0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(8'h0C, 32'h3F); rd(8'h0C, v); check("R6 direct m0 blocked", v, 0);
    wr(8'h08, 32'h3F); rd(8'h08, v); check("R6 direct m1 blocked", v, 0);
    wr(8'h54, 32'h3F); rd(8'h0C, v); check("R6 m0 set blocked", v, 0);
    wr(8'h14, 32'h05); ed = 6'h05;
    check_pads("R6 data set not gated");
  endtask

  task automatic t_modes();
    logic [31:0] v;
    wr(8'h00, 32'hD42F);
    wr(8'h0C, 32'h3A); em0 = 6'h3A; rd(8'h0C, v); check("R3 direct m0", v, 32'h3A);
    wr(8'h08, 32'h2C); em1 = 6'h2C; rd(8'h08, v); check("R3 direct m1", v, 32'h2C);
    check_pads("R4 pattern a");
    wr(8'h14, 32'h3F); ed = 6'h3F; check_pads("R2 R4 all data high");
    wr(8'h18, 32'h2A); ed = 6'h15; check_pads("R2 R4 clear odd");
    wr(8'h58, 32'h08); em0 = em0 & ~6'h08; rd(8'h0C, v); check("R3 m0 clr", v, 32'(em0));
    wr(8'h54, 32'h05); em0 = em0 | 6'h05; rd(8'h0C, v); check("R3 m0 set", v, 32'(em0));
    wr(8'h50, 32'h24); em1 = em1 & ~6'h24; rd(8'h08, v); check("R3 m1 clr", v, 32'(em1));
    check_pads("R4 pattern b");
    wr(8'h08, 32'h3F); em1 = 6'h3F; wr(8'h0C, 32'h0F); em0 = 6'h0F;
    check_pads("R4 sink and source");
    wr(8'h18, 32'h3F); ed = 6'h00; check_pads("R4 data low");
  endtask

  task automatic t_unimpl();
    logic [31:0] v;
    wr(8'h0C, 32'hFFFF_FFFF); em0 = 6'h3F; rd(8'h0C, v); check("R8 upper bits", v, 32'h3F);
    rd(8'h14, v); check("R8 alias reads 0", v, 0);
    rd(8'h54, v); check("R8 alias reads 0", v, 0);
    rd(8'h30, v); check("R8 unmapped", v, 0);
    wr(8'h00, 32'h0);
    wr(8'h08, 32'h0); rd(8'h08, v); check("R6 blocked after disarm", v, 32'(em1));
  endtask

  task automatic t_sync();
    logic [31:0] v;
    rd(8'h04, v); check("R7 idle", v, 0);
    pad_in = 6'h2A;
    rd(8'h04, v); check("R7 edge1 old", v, 0);
    rd(8'h04, v); check("R7 edge2 old", v, 0);
    rd(8'h04, v); check("R7 edge3 new", v, 32'h2A);
    pad_in = 6'h00;
    repeat (3) @(negedge clk);
    check("R9 read data held", rd_data, 32'h2A);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_key();
    t_gate();
    t_modes();
    t_unimpl();
    t_sync();
    report();
    $finish;
  end

endmodule